// File: doc/BRIEF.md
# Serial Byte Memory Slave with Busy Polling

This block is the two-wire serial slave side of a small byte memory. It watches oversampled clock and data lines, finds START and STOP framing, and compares the first byte of every transfer with its own 7-bit device address. A write transfer carries a word address and then data bytes. Each data byte is stored at the internal address pointer, and the pointer then advances. The STOP that closes a write that stored at least one byte starts a timed internal write cycle. While that cycle runs, the slave answers nothing, so a master can poll the slave with its address until it gets an acknowledge.

A read transfer returns the byte at the address pointer, most significant bit first. The pointer advances after every byte that is sent. If the master acknowledges, the next byte follows. If the master does not acknowledge, the slave releases the data line and waits for STOP. A write that carries only the word address sets the pointer without starting a write cycle, and a following read then starts from that address.

Top module: `i2c_mem_slave`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `busy` is 0 and `sda_oe` is 0.
- R2: When `busy` is 0, a first byte whose upper 7 bits equal DEV_ADDR is acknowledged on the ninth clock, whether bit 0 (1 = read, 0 = write) is 0 or 1. Any other address leaves SDA released on the ninth clock.
- R3: In a write, the byte after the device address sets the pointer, using its low log2(DEPTH) bits. Each further byte is acknowledged, stored at the pointer, and the pointer then advances, wrapping from DEPTH-1 to 0.
- R4: A STOP that ends a write in which at least one data byte was stored raises `busy` within a few system clocks. `busy` then stays high for WCYC clocks and no more.
- R5: While `busy` is 1, a matching address gets no acknowledge and the slave never drives SDA. Bytes that follow are not stored.
- R6: An acknowledged read address is followed by the byte at the pointer, shifted out MSB first. The pointer advances by one after each byte sent.
- R7: If the master acknowledges a read byte, the slave sends the byte at the advanced pointer. Reading past DEPTH-1 continues at address 0.
- R8: If the master does not acknowledge a read byte, the slave leaves SDA released on every later clock until the next STOP or START.
- R9: A write that ends with STOP right after the word address sets the pointer and leaves `busy` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bus lines are oversampled on it |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy | output | 1 | High while the internal write cycle runs |

## Verification
A wrong pointer shows up in the very next read byte as data from the wrong address. Sequential reads across the top of the memory expose a bad wrap within one byte. A bad bit counter or shift register shifts or corrupts the first read byte, or moves the acknowledge off the ninth clock, and the master sees that on the same transfer. A busy timer that is too long or too short is caught by a poll placed inside the window and by counting cycles until `busy` drops. State left over after a NACK shows up as SDA pulled low on the extra clocks the bench sends before STOP.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [3:0] {
    S_IDLE,  // waiting for START
    S_DEV,   // shifting device address
    S_ACKD,  // acknowledging device address
    S_WADR,  // shifting word address
    S_ACKA,  // acknowledging word address
    S_WDAT,  // shifting write data
    S_ACKW,  // acknowledging write data
    S_RDAT,  // shifting out read data
    S_RACK,  // master acknowledge slot
    S_HOLD   // released, waiting for STOP or START
  } bus_st_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES:0] scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign scl_rise = scl_q[STAGES-1] & ~scl_q[STAGES];
  assign scl_fall = ~scl_q[STAGES-1] & scl_q[STAGES];
  assign start_p  = scl_q[STAGES-1] & scl_q[STAGES] & sda_q[STAGES] & ~sda_q[STAGES-1];
  assign stop_p   = scl_q[STAGES-1] & scl_q[STAGES] & ~sda_q[STAGES] & sda_q[STAGES-1];
endmodule

// File: rtl/i2c_busy_timer.sv
module i2c_busy_timer #(
  parameter int WCYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic busy
);
  localparam int CW = $clog2(WCYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (go) begin
      cnt  <= CW'(WCYC - 1);
      busy <= 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_mem_store.sv
module i2c_mem_store #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int DEPTH  = 16,
  parameter int WCYC   = 64,
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic busy
);
  localparam int AW = $clog2(DEPTH);

  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  bus_st_t st;
  logic [3:0] bcnt;
  logic [7:0] sh, mem_rd, rd_byte, mem_wd;
  logic [AW-1:0] aptr, mem_wa;
  logic aval, rw, mack, wrote, wr_go, mem_we;

  i2c_line_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  i2c_busy_timer #(.WCYC(WCYC)) u_timer (
    .clk(clk), .rst(rst), .go(wr_go), .busy(busy)
  );

  i2c_mem_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
    .raddr(aptr), .rdata(mem_rd)
  );

  // pointer not yet set: return all ones
  assign rd_byte = aval ? mem_rd : 8'hFF;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      bcnt   <= '0;
      sh     <= '0;
      aptr   <= '0;
      aval   <= 1'b0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      wrote  <= 1'b0;
      wr_go  <= 1'b0;
      sda_oe <= 1'b0;
      mem_we <= 1'b0;
      mem_wa <= '0;
      mem_wd <= '0;
    end else begin
      mem_we <= 1'b0;
      wr_go  <= 1'b0;
      if (start_p) begin
        st     <= S_DEV;
        bcnt   <= '0;
        sda_oe <= 1'b0;
        wrote  <= 1'b0;
      end else if (stop_p) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        wr_go  <= wrote;
        wrote  <= 1'b0;
      end else begin
        if ((st == S_DEV || st == S_WADR || st == S_WDAT) && scl_rise) begin
          sh   <= {sh[6:0], sda_s};
          bcnt <= bcnt + 1'b1;
        end
        unique case (st)
          S_DEV: if (scl_fall && bcnt == 4'd8) begin
            bcnt <= '0;
            if (sh[7:1] == DEV_ADDR && !busy) begin
              sda_oe <= 1'b1;
              rw     <= sh[0];
              st     <= S_ACKD;
            end else begin
              st <= S_HOLD;
            end
          end
          S_WADR: if (scl_fall && bcnt == 4'd8) begin
            bcnt   <= '0;
            aptr   <= sh[AW-1:0];
            aval   <= 1'b1;
            sda_oe <= 1'b1;
            st     <= S_ACKA;
          end
          S_WDAT: if (scl_fall && bcnt == 4'd8) begin
            bcnt   <= '0;
            mem_we <= 1'b1;
            mem_wa <= aptr;
            mem_wd <= sh;
            aptr   <= aptr + 1'b1;
            wrote  <= 1'b1;
            sda_oe <= 1'b1;
            st     <= S_ACKW;
          end
          S_ACKD: if (scl_fall) begin
            bcnt <= '0;
            if (rw) begin
              sh     <= rd_byte;
              sda_oe <= ~rd_byte[7];
              st     <= S_RDAT;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_WADR;
            end
          end
          S_ACKA, S_ACKW: if (scl_fall) begin
            sda_oe <= 1'b0;
            bcnt   <= '0;
            st     <= S_WDAT;
          end
          S_RDAT: begin
            if (scl_rise) begin
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall) begin
              if (bcnt == 4'd8) begin
                sda_oe <= 1'b0;
                aptr   <= aptr + 1'b1;
                st     <= S_RACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              bcnt <= '0;
              if (mack) begin
                sh     <= rd_byte;
                sda_oe <= ~rd_byte[7];
                st     <= S_RDAT;
              end else begin
                st <= S_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_chk.sv
module i2c_mem_chk #(
  parameter int WCYC = 64
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic sda_oe,
  input logic scl_s,
  input logic stop_p
);
  logic [31:0] run;

  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else     run <= busy ? run + 1 : '0;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> (!busy && !sda_oe));

  // R5
  busy_silent_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe);

  // R4
  busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_p, 2));

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    run <= 32'(WCYC));

  // R2
  drive_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);
endmodule

bind i2c_mem_slave i2c_mem_chk #(.WCYC(WCYC)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .sda_oe(sda_oe),
  .scl_s(scl_s), .stop_p(stop_p)
);

// File: tb/sim_i2c_mem_slave.sv
module sim_i2c_mem_slave;
  localparam logic [6:0] DEV = 7'h50;
  localparam int DEPTH = 16;
  localparam int WCYC  = 400;
  localparam int Q     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, busy;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] mm [DEPTH];
  int cm = 0;

  always #10 clk = ~clk;

  i2c_mem_slave #(.DEV_ADDR(DEV), .DEPTH(DEPTH), .WCYC(WCYC)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1'b1;   tick(2*Q);
      scl = 1'b0;   tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    ack = !sda_line;
    tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b = {b[6:0], sda_line};
      tick(Q);
      scl = 1'b0;
    end
    sda_m = !mack; tick(Q);
    scl = 1'b1;    tick(2*Q);
    scl = 1'b0;    tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < WCYC + 100) begin tick(1); n++; end
    chk(!busy, "R4 busy clears", int'(busy), 0);
  endtask

  task automatic wr_burst(input int a, input int n);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk(ack, "R2 write address ack", int'(ack), 1);
    send_byte(8'(a), ack);
    chk(ack, "R3 word address ack", int'(ack), 1);
    cm = a % DEPTH;
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom);
      send_byte(b, ack);
      chk(ack, "R3 data ack", int'(ack), 1);
      mm[cm] = b;
      cm = (cm + 1) % DEPTH;
    end
    bus_stop();
  endtask

  task automatic set_ptr(input int a);
    bit ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk(ack, "R9 address ack", int'(ack), 1);
    send_byte(8'(a), ack);
    chk(ack, "R9 word address ack", int'(ack), 1);
    bus_stop();
    cm = a % DEPTH;
    tick(6);
    chk(!busy, "R9 no write cycle", int'(busy), 0);
  endtask

  task automatic rd_burst(input int n);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    chk(ack, "R2 read address ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      read_byte(i < n - 1, b);
      if (i == 0) chk(b == mm[cm], "R6 read data", int'(b), int'(mm[cm]));
      else        chk(b == mm[cm], "R7 sequential data", int'(b), int'(mm[cm]));
      cm = (cm + 1) % DEPTH;
    end
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    int c;
    bit line_ok;
    void'($urandom(32'd1234));
    tick(5);
    chk(!busy && !sda_oe, "R1 reset outputs", int'({busy, sda_oe}), 0);
    rst = 1'b0;
    tick(1);
    chk(!busy && !sda_oe, "R1 after release", int'({busy, sda_oe}), 0);

    // fill whole memory; pointer wraps back to 0 (R3)
    wr_burst(0, DEPTH);
    tick(2);
    chk(busy, "R4 busy after stop", int'(busy), 1);
    // poll while busy: no ack, following bytes ignored (R5)
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk(!ack, "R5 poll nack", int'(ack), 0);
    send_byte(8'd5, ack);
    send_byte(8'hA5, ack);
    bus_stop();
    wait_idle();
    set_ptr(5);
    rd_burst(1);

    // busy length (R4)
    wr_burst(3, 1);
    c = 0;
    while (busy && c < WCYC + 50) begin tick(1); c++; end
    chk(c >= WCYC - 12 && c <= WCYC, "R4 busy length", c, WCYC);

    // both directions acked once idle (R2)
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk(ack, "R2 write poll ack", int'(ack), 1);
    bus_stop();
    rd_burst(2);

    // foreign address (R2)
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b1}, ack);
    chk(!ack, "R2 foreign nack", int'(ack), 0);
    bus_stop();

    // wrap on sequential read (R7)
    set_ptr(14);
    rd_burst(4);
    chk(cm == 2, "R7 pointer wrap", cm, 2);

    // NACK releases the line (R8)
    set_ptr(2);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    read_byte(1'b0, b);
    chk(b == mm[cm], "R6 single read", int'(b), int'(mm[cm]));
    cm = (cm + 1) % DEPTH;
    line_ok = 1'b1;
    sda_m = 1'b1;
    for (int i = 0; i < 9; i++) begin
      tick(Q); scl = 1'b1; tick(Q);
      if (!sda_line) line_ok = 1'b0;
      tick(Q); scl = 1'b0;
    end
    tick(Q);
    chk(line_ok, "R8 released after nack", int'(line_ok), 1);
    bus_stop();
    rd_burst(1);

    // random mix
    for (int k = 0; k < 40; k++) begin
      int op = int'($urandom_range(0, 2));
      if (op == 0) begin
        wr_burst(int'($urandom_range(0, 255)), int'($urandom_range(1, 3)));
        wait_idle();
      end else if (op == 1) begin
        rd_burst(int'($urandom_range(1, 4)));
      end else begin
        set_ptr(int'($urandom_range(0, 255)));
        rd_burst(int'($urandom_range(1, 3)));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule